// File: doc/BRIEF.md
# Clock Ratio Measurement Registers with Coherent Byte Readout

This block measures the rate of a data clock against the master clock it runs on. Its result is an unsigned 32-bit fixed-point ratio: the data-clock frequency divided by the master-clock frequency, multiplied by 2^32. A data clock of 2.8224 MHz against a 90.3168 MHz master clock reads as 0x08000000. The data clock arrives as a one-cycle edge strobe that is already synchronous to the master clock. The block counts master cycles over a window of 2^WIN_LOG2 data edges. A sequential restoring divider then turns that count into the ratio, and the finished quotient is committed to a live register once per completed measurement.

A host reads the result through a byte-wide register-read port at four consecutive addresses, least significant byte first. The live value normally wanders by about one LSB. That wander can ripple a carry through every byte, for example from 0x07FFFFFF to 0x08000000. A plain byte-by-byte readout could then assemble nonsense such as 0x08FFFFFF or 0x07000000. To prevent this, reading the lowest address copies the whole live word into a shadow register at the same clock edge. The three upper bytes are served from that shadow only, so the four bytes always form one word.

Top module: `clk_ratio_regs`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the live register, the shadow register and the read-data output are all zero.
- R2: After a window of 2^WIN_LOG2 data edges spanning C master cycles, the live value becomes floor(2^(32+WIN_LOG2) / C). C counts every master cycle from the cycle after the previous window closed up to and including the closing edge's cycle. The live value updates once per completed measurement.
- R3: A quotient of 2^32 or more, for example a data edge on every master cycle, saturates the live value to 0xFFFFFFFF.
- R4: Byte k of the word (bits 8k+7..8k) sits at address REG_BASE+k, for k = 0..3. The default REG_BASE is 28, so address 28 holds the least significant byte and address 31 the most significant.
- R5: A read of address REG_BASE copies the full live word into the shadow register at the same edge and returns byte 0 of the live word.
- R6: Reads of addresses REG_BASE+1 to REG_BASE+3 return bytes of the shadow register, never of the live register.
- R7: The shadow register holds its value until the next read of address REG_BASE, however often the live value changes in between.
- R8: A read of any address outside REG_BASE to REG_BASE+3 returns 0x00.
- R9: Read data appears on rdData in the cycle after the read strobe is sampled, and it holds until the next read strobe.
- R10: A window that closes while the divider is still busy is discarded. The next window is then measured from scratch, so a fast data clock still yields a correct ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataEdge | input | 1 | One-cycle strobe per data-clock edge, synchronous to clk |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 8 | Registered read data byte |

## Verification
The bench builds the block with WIN_LOG2 = 2, so a measurement window is only four data edges. The divider then finishes in 35 cycles, and the live value turns over every 128 or 129 master cycles. This puts several live updates between two byte reads at little cost. It also lets a generator alternate the window between 128 and 129 cycles, which moves the live value back and forth across a carry from 0x08000000 to 0x07F01FC0 that touches every byte. The short window also brings the saturation case and the discarded-window case within reach of a one-cycle edge spacing.

// File: rtl/ratio_pkg.sv
package ratio_pkg;

  // Strobes from the control to the datapath, one per action.
  typedef struct packed {
    logic       winClose;    // last data edge of a window seen this cycle
    logic       divLoad;     // capture the window length, clear the divider
    logic       divStep;     // perform one restoring-division step
    logic       numBit;      // numerator bit fed into this step
    logic       liveCommit;  // move the finished quotient into the live register
    logic       snapTake;    // copy live into shadow (read of lowest byte)
    logic       rdLoad;      // update the read-data byte
    logic       rdHit;       // read address falls inside the four-byte block
    logic [1:0] rdSel;       // byte index inside the block
  } ratioStrobes_t;

  typedef enum logic [1:0] {
    DivIdle   = 2'd0,
    DivRun    = 2'd1,
    DivCommit = 2'd2
  } divState_t;

  localparam int unsigned RATIO_W = 32;

endpackage

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import ratio_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_BASE = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataEdge,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ratioStrobes_t     strb
);

  localparam int unsigned DIV_STEPS = RATIO_W + 1 + WIN_LOG2;
  localparam int unsigned STEP_W    = $clog2(DIV_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DIV_STEPS - 1);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(REG_BASE);

  logic [WIN_LOG2-1:0] edgeCnt;
  logic [STEP_W-1:0]   stepCnt;
  divState_t           divState;
  logic                winDone;
  logic [ADDR_W-1:0]   rdOffset;

  assign winDone = dataEdge && (edgeCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (dataEdge) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divState <= DivIdle;
      stepCnt  <= '0;
    end else begin
      unique case (divState)
        DivIdle: if (winDone) begin
          divState <= DivRun;
          stepCnt  <= '0;
        end
        DivRun: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) divState <= DivCommit;
        end
        DivCommit: divState <= DivIdle;
        default:   divState <= DivIdle;
      endcase
    end
  end

  assign rdOffset = rdAddr - BASE_ADDR;

  always_comb begin
    strb            = '0;
    strb.winClose   = winDone;
    strb.divLoad    = (divState == DivIdle) && winDone;
    strb.divStep    = (divState == DivRun);
    strb.numBit     = (divState == DivRun) && (stepCnt == '0);
    strb.liveCommit = (divState == DivCommit);
    strb.rdHit      = (rdOffset < ADDR_W'(4));
    strb.rdSel      = rdOffset[1:0];
    strb.rdLoad     = rdEn;
    strb.snapTake   = rdEn && strb.rdHit && (rdOffset[1:0] == 2'd0);
  end

endmodule

// File: rtl/ratio_datapath.sv
module ratio_datapath
  import ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  ratioStrobes_t       strb,
  output logic [RATIO_W-1:0]  liveVal,
  output logic [RATIO_W-1:0]  shadowVal,
  output logic [7:0]          rdData
);

  localparam logic [CNT_W-1:0] CNT_CAP = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0]   cycCnt;
  logic [CNT_W-1:0]   divisor;
  logic [CNT_W-1:0]   rem;
  logic [RATIO_W-1:0] quo;
  logic               ovf;
  logic [CNT_W:0]     remShift;
  logic [CNT_W:0]     remDiff;
  logic               fits;
  logic [7:0]         byteSel;

  // Master cycles since the previous window closed; saturates so that
  // cycCnt + 1 never wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (strb.winClose) begin
      cycCnt <= '0;
    end else if (cycCnt != CNT_CAP) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assign remShift = {rem, strb.numBit};
  assign remDiff  = remShift - {1'b0, divisor};
  assign fits     = (remShift >= {1'b0, divisor});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
      rem     <= '0;
      quo     <= '0;
      ovf     <= 1'b0;
    end else if (strb.divLoad) begin
      divisor <= cycCnt + 1'b1;
      rem     <= '0;
      quo     <= '0;
      ovf     <= 1'b0;
    end else if (strb.divStep) begin
      rem     <= fits ? remDiff[CNT_W-1:0] : remShift[CNT_W-1:0];
      quo     <= {quo[RATIO_W-2:0], fits};
      ovf     <= ovf | quo[RATIO_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveVal <= '0;
    end else if (strb.liveCommit) begin
      liveVal <= ovf ? '1 : quo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowVal <= '0;
    end else if (strb.snapTake) begin
      shadowVal <= liveVal;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      2'd0:    byteSel = liveVal[7:0];
      2'd1:    byteSel = shadowVal[15:8];
      2'd2:    byteSel = shadowVal[23:16];
      default: byteSel = shadowVal[31:24];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdLoad) begin
      rdData <= strb.rdHit ? byteSel : 8'h00;
    end
  end

endmodule

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import ratio_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 8,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_BASE = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataEdge,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  ratioStrobes_t      strb;
  logic [RATIO_W-1:0] liveVal;
  logic [RATIO_W-1:0] shadowVal;

  ratio_ctrl #(
    .WIN_LOG2 (WIN_LOG2),
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataEdge (dataEdge),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .strb     (strb)
  );

  ratio_datapath #(
    .CNT_W (CNT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .liveVal   (liveVal),
    .shadowVal (shadowVal),
    .rdData    (rdData)
  );

endmodule

// File: rtl/clk_ratio_regs_chk.sv
module clk_ratio_regs_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_BASE = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic [31:0]       liveVal,
  input logic [31:0]       shadowVal
);

  logic readLow;
  logic readUpper;
  logic readOutside;

  assign readLow     = rdEn && (rdAddr == ADDR_W'(REG_BASE));
  assign readUpper   = rdEn && (rdAddr >= ADDR_W'(REG_BASE + 1)) && (rdAddr <= ADDR_W'(REG_BASE + 3));
  assign readOutside = rdEn && ((rdAddr < ADDR_W'(REG_BASE)) || (rdAddr > ADDR_W'(REG_BASE + 3)));

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (liveVal == '0) && (shadowVal == '0) && (rdData == '0));

  a_r5_snap_copies_live: assert property (@(posedge clk) disable iff (!rstN)
    readLow |=> (shadowVal == $past(liveVal)) && (rdData == $past(liveVal[7:0])));

  a_r6_upper_from_shadow: assert property (@(posedge clk) disable iff (!rstN)
    readUpper |=> rdData == (shadowVal >> (8 * ($past(rdAddr) - ADDR_W'(REG_BASE)))) % 256);

  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rstN)
    !readLow |=> $stable(shadowVal));

  a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rstN)
    readOutside |=> rdData == 8'h00);

  a_r9_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind clk_ratio_regs clk_ratio_regs_chk #(
  .ADDR_W   (ADDR_W),
  .REG_BASE (REG_BASE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .liveVal   (liveVal),
  .shadowVal (shadowVal)
);

// File: tb/clk_ratio_regs_test.sv
`timescale 1ns/1ps
module clk_ratio_regs_test;

  localparam int unsigned WIN_LOG2 = 2;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned BASE     = 28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dataEdge = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  rdData;

  int checks = 0;
  int fails  = 0;
  int winCycles = 0;   // master cycles per window, 0 = no data edges
  bit jitter = 1'b0;   // alternate 128 / 129 cycle windows
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clk_ratio_regs #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .REG_BASE (BASE)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .dataEdge (dataEdge),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

  function automatic logic [31:0] expRatio(int c);
    logic [63:0] q;
    q = (64'd1 << (32 + WIN_LOG2)) / 64'(c);
    return (q > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Data-edge generator: four edges per window, the last gap absorbs the remainder.
  initial begin
    @(negedge clk);
    forever begin
      if (winCycles == 0) begin
        dataEdge = 1'b0;
        @(negedge clk);
      end else begin
        for (int k = 0; k < 4; k++) begin
          int gap;
          gap = (k == 3) ? winCycles - 3 * (winCycles / 4) : winCycles / 4;
          dataEdge = 1'b1;
          @(negedge clk);
          dataEdge = 1'b0;
          repeat (gap - 1) @(negedge clk);
        end
        if (jitter) winCycles = (winCycles == 128) ? 129 : 128;
      end
    end
  end

  task automatic readByte(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      readByte(8'(BASE + k), b);
      w[8*k +: 8] = b;
    end
  endtask

  task automatic settle(int cyc);
    winCycles = cyc;
    repeat (cyc * 4 + 120) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] w;
    check(rdData == 8'h00, "R1 rdData after reset", 32'(rdData), 32'h0);
    readWord(w);
    check(w == 32'h0, "R1 word after reset", w, 32'h0);
  endtask

  task automatic testSteady(int cyc, string req);
    logic [31:0] w;
    settle(cyc);
    readWord(w);
    check(w == expRatio(cyc), req, w, expRatio(cyc));
  endtask

  task automatic testOutside();
    logic [7:0] d;
    logic [7:0] addrs [4] = '{8'd0, 8'd27, 8'd32, 8'd255};
    foreach (addrs[i]) begin
      readByte(addrs[i], d);
      check(d == 8'h00, "R8 outside address", 32'(d), 32'h0);
    end
  endtask

  task automatic testHold();
    logic [7:0] d;
    readByte(8'(BASE + 3), d);
    repeat (20) @(negedge clk);
    check(rdData == d, "R9 rdData holds without read", 32'(rdData), 32'(d));
  endtask

  task automatic testCoherent();
    logic [31:0] w;
    logic [7:0]  b;
    logic [7:0]  again;
    logic [31:0] ea = expRatio(128);
    logic [31:0] eb = expRatio(129);
    jitter = 1'b1;
    winCycles = 128;
    repeat (1200) @(negedge clk);
    for (int r = 0; r < 12; r++) begin
      readByte(8'(BASE), b);
      w[7:0] = b;
      repeat (150 + 37 * r) @(negedge clk);  // live changes in between
      for (int k = 1; k < 4; k++) begin
        readByte(8'(BASE + k), b);
        w[8*k +: 8] = b;
        repeat (61) @(negedge clk);
      end
      check((w == ea) || (w == eb), "R5 R6 coherent word across carry", w, ea);
      repeat (300) @(negedge clk);
      readByte(8'(BASE + 3), again);
      check(again == w[31:24], "R7 shadow held until next low read", 32'(again), 32'(w[31:24]));
    end
    jitter = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testSteady(128, "R2 R4 ratio 1/32 = 0x08000000");
    testSteady(129, "R2 R4 ratio window 129");
    testSteady(8,   "R2 ratio 1/2 = 0x80000000");
    testSteady(4,   "R3 R10 edge every cycle saturates");
    testSteady(200, "R2 ratio window 200");
    testOutside();
    testHold();
    testCoherent();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule